// File: doc/BRIEF.md
# Reduced-State Keccak Sponge Core

This core is the hashing engine of a compact signature accelerator. It holds a 400-bit Keccak state made of twenty-five 16-bit lanes and runs it as an extendable-output sponge whose rate is 128 bits. A caller feeds one 128-bit block per command. A start command clears the state before absorbing the block. A continue command absorbs the block into whatever state the previous operation left. Either command is followed by the 20-round Keccak-f[400] permutation. Output is taken from the rate portion of the state. More output is squeezed by issuing a continue with an all-zero block.

The permutation runs at one full round per clock. The round datapath is purely combinational and is applied to a single state register. Round constants are not stored. They are derived from a 5-bit LFSR that also serves as the round counter. Padding, message framing and the sequencing of multi-block messages are left to the caller.

Top module: `k400_sponge`

## Requirements
- R1: After a synchronous reset, `busy_o` and `done_o` are low and `digest_o` is all zeros.
- R2: A start accepted while idle sets the state to zero, XORs `block_i` bit k into state bit k (lanes 0 to 7, lane i at state bits 16i+15..16i), then applies 20 rounds of Keccak-f[400]. The rho offsets are the standard ones reduced modulo 16, and iota uses the low 16 bits of the standard round constants.
- R3: A continue accepted while idle XORs `block_i` into the retained state instead of a cleared one, then applies the same permutation.
- R4: A continue with an all-zero block returns the next 128 output bits of the sponge (a squeeze), and repeated squeezes keep advancing the stream.
- R5: `busy_o` rises on the clock edge that accepts a command and stays high for exactly 20 cycles. The state advances one round on each of those cycles.
- R6: `done_o` is high for exactly one cycle, namely the first cycle after `busy_o` falls. `digest_o` equals state bits 127..0 and holds its value while the core is idle with no command.
- R7: A start or continue that arrives while `busy_o` is high is ignored. It does not change the result or produce an extra `done_o`.
- R8: When start and continue are both high in an idle cycle, the start takes effect and the state is cleared first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new sponge from a zero state with `block_i` |
| cont_i | input | 1 | Absorb `block_i` into the retained state |
| block_i | input | 128 | Block XORed into the rate portion |
| digest_o | output | 128 | Rate portion of the state (lanes 0..7) |
| busy_o | output | 1 | Permutation rounds in progress |
| done_o | output | 1 | One-cycle pulse, result valid |

## Verification
The scoreboard predicts every output with an independent Keccak-f[400] model. That model uses its own table of rho offsets and round constants. A single wrong offset, constant or lane mapping therefore shows up as a digest mismatch. Chained continues and squeezes catch a core that clears the state when it should not. A start issued together with a continue, after a non-zero state, catches a core that gives continue priority. Commands injected in the middle of a run test whether the core restarts or re-absorbs. A core that did so would produce a wrong digest or an extra done pulse. Each done pulse is also checked for a busy window of exactly 20 cycles, which exposes a round counter that is off by one.

// File: rtl/k400_pkg.sv
package k400_pkg;

  localparam logic [4:0] RND_SEED = 5'b00001;

  // Next value of the round-counter LFSR (x^5 + x^3 + 1, maximal length)
  function automatic logic [4:0] lfsr_step(input logic [4:0] s);
    return {s[3:0], s[4] ^ s[2]};
  endfunction

  // Standard Keccak rho offset for lane (x, y), obtained by walking the lane cycle
  function automatic int rho_offset(input int x, input int y);
    int cx;
    int cy;
    int tmp;
    cx = 1;
    cy = 0;
    if (x == 0 && y == 0) return 0;
    for (int t = 0; t < 24; t++) begin
      if (cx == x && cy == y) return ((t + 1) * (t + 2)) / 2;
      tmp = cx;
      cx  = cy;
      cy  = (2 * tmp + 3 * cy) % 5;
    end
    return 0;
  endfunction

  // Output bit t of the degree-8 round-constant LFSR
  function automatic logic rc_seq_bit(input int t);
    logic [7:0] r;
    logic       msb;
    r = 8'h01;
    for (int k = 0; k < (t % 255); k++) begin
      msb = r[7];
      r   = {r[6:0], 1'b0};
      if (msb) r = r ^ 8'h71;
    end
    return r[0];
  endfunction

endpackage

// File: rtl/k400_rcgen.sv
module k400_rcgen
  import k400_pkg::*;
#(
  parameter int LANE_W     = 16,
  parameter int NUM_ROUNDS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [LANE_W-1:0] rc_o,
  output logic              last_o
);

  localparam int LOG_W = $clog2(LANE_W);

  // Truth table of one round-constant bit over the 32 LFSR states
  function automatic logic [31:0] build_tt(input int j);
    logic [31:0] tt;
    logic [4:0]  s;
    tt = '0;
    s  = RND_SEED;
    for (int i = 0; i < NUM_ROUNDS; i++) begin
      tt[s] = rc_seq_bit(j + 7 * i);
      s     = lfsr_step(s);
    end
    return tt;
  endfunction

  function automatic logic [4:0] final_state();
    logic [4:0] s;
    s = RND_SEED;
    for (int i = 1; i < NUM_ROUNDS; i++) s = lfsr_step(s);
    return s;
  endfunction

  localparam logic [4:0] RND_LAST = final_state();

  logic [4:0]       lfsr_q;
  logic [LOG_W:0]   rc_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= RND_SEED;
    end else if (advance) begin
      lfsr_q <= last_o ? RND_SEED : lfsr_step(lfsr_q);
    end
  end

  generate
    for (genvar j = 0; j <= LOG_W; j++) begin : g_rcbit
      localparam logic [31:0] TT = build_tt(j);
      assign rc_bits[j] = TT[lfsr_q];
    end
  endgenerate

  always_comb begin
    rc_o = '0;
    for (int j = 0; j <= LOG_W; j++) rc_o[(1 << j) - 1] = rc_bits[j];
  end

  assign last_o = (lfsr_q == RND_LAST);

endmodule

// File: rtl/k400_round.sv
module k400_round
  import k400_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic [25*LANE_W-1:0] st_i,
  input  logic [LANE_W-1:0]    rc_i,
  output logic [25*LANE_W-1:0] st_o
);

  typedef logic [LANE_W-1:0] lane_t;

  lane_t a [25];
  lane_t t [25];
  lane_t b [25];
  lane_t e [25];
  lane_t c [5];
  lane_t d [5];

  generate
    for (genvar i = 0; i < 25; i++) begin : g_unpack
      assign a[i] = st_i[i*LANE_W +: LANE_W];
    end

    // theta: column parities and their mix
    for (genvar x = 0; x < 5; x++) begin : g_col
      assign c[x] = a[x] ^ a[x+5] ^ a[x+10] ^ a[x+15] ^ a[x+20];
      assign d[x] = c[(x+4)%5] ^ {c[(x+1)%5][LANE_W-2:0], c[(x+1)%5][LANE_W-1]};
    end

    for (genvar i = 0; i < 25; i++) begin : g_theta
      assign t[i] = a[i] ^ d[i%5];
    end

    // rho and pi: fixed rotation and lane move
    for (genvar x = 0; x < 5; x++) begin : g_rx
      for (genvar y = 0; y < 5; y++) begin : g_ry
        localparam int ROT = rho_offset(x, y) % LANE_W;
        localparam int DST = y + 5 * ((2 * x + 3 * y) % 5);
        if (ROT == 0) begin : g_norot
          assign b[DST] = t[x+5*y];
        end else begin : g_rot
          assign b[DST] = {t[x+5*y][LANE_W-1-ROT:0], t[x+5*y][LANE_W-1:LANE_W-ROT]};
        end
      end
    end

    // chi along rows
    for (genvar x = 0; x < 5; x++) begin : g_cx
      for (genvar y = 0; y < 5; y++) begin : g_cy
        assign e[x+5*y] = b[x+5*y] ^ (~b[(x+1)%5+5*y] & b[(x+2)%5+5*y]);
      end
    end

    // iota on lane 0, pack
    for (genvar i = 0; i < 25; i++) begin : g_pack
      if (i == 0) begin : g_iota
        assign st_o[i*LANE_W +: LANE_W] = e[i] ^ rc_i;
      end else begin : g_pass
        assign st_o[i*LANE_W +: LANE_W] = e[i];
      end
    end
  endgenerate

endmodule

// File: rtl/k400_sponge.sv
module k400_sponge #(
  parameter int LANE_W     = 16,
  parameter int RATE_W     = 128,
  parameter int NUM_ROUNDS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic [RATE_W-1:0] block_i,
  output logic [RATE_W-1:0] digest_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int STATE_W = 25 * LANE_W;

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] absorb_base;
  logic [STATE_W-1:0] absorb_val;
  logic [STATE_W-1:0] round_out;
  logic [LANE_W-1:0]  rc;
  logic               last_rnd;
  logic               accept;

  assign accept = !busy_o && (start_i || cont_i);

  // shared absorb/squeeze path: start clears, continue keeps
  always_comb begin
    absorb_base = start_i ? '0 : state_q;
    absorb_val  = absorb_base ^ {{(STATE_W-RATE_W){1'b0}}, block_i};
  end

  k400_rcgen #(
    .LANE_W    (LANE_W),
    .NUM_ROUNDS(NUM_ROUNDS)
  ) u_rcgen (
    .clk    (clk),
    .rst    (rst),
    .advance(busy_o),
    .rc_o   (rc),
    .last_o (last_rnd)
  );

  k400_round #(
    .LANE_W(LANE_W)
  ) u_round (
    .st_i(state_q),
    .rc_i(rc),
    .st_o(round_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (busy_o) begin
        state_q <= round_out;
        if (last_rnd) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end else if (accept) begin
        state_q <= absorb_val;
        busy_o  <= 1'b1;
      end
    end
  end

  assign digest_o = state_q[RATE_W-1:0];

endmodule

// File: rtl/k400_sponge_chk.sv
module k400_sponge_chk #(
  parameter int RATE_W     = 128,
  parameter int NUM_ROUNDS = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              cont_i,
  input logic [RATE_W-1:0] digest_o,
  input logic              busy_o,
  input logic              done_o
);

  localparam int CNT_W = $clog2(NUM_ROUNDS + 2);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)         run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (run_cnt == CNT_W'(NUM_ROUNDS)));

  // R5
  busy_begin_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && (start_i || cont_i)) |=> busy_o);

  // R7
  busy_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && run_cnt != CNT_W'(NUM_ROUNDS - 1)) |=> busy_o);

  // R6
  done_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i && !cont_i) |=> $stable(digest_o));

endmodule

bind k400_sponge k400_sponge_chk #(
  .RATE_W    (RATE_W),
  .NUM_ROUNDS(NUM_ROUNDS)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .cont_i  (cont_i),
  .digest_o(digest_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/k400_sponge_tb.sv
module k400_sponge_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         cont_i = 1'b0;
  logic [127:0] block_i = '0;
  logic [127:0] digest_o;
  logic         busy_o;
  logic         done_o;

  int total = 0;
  int bad = 0;
  int done_cnt = 0;
  int busy_run = 0;
  logic [399:0] model = '0;
  logic [127:0] exp_q[$];
  string        tag_q[$];
  logic [127:0] last_exp = '0;

  always #5 clk = ~clk;

  k400_sponge u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .cont_i(cont_i),
    .block_i(block_i), .digest_o(digest_o), .busy_o(busy_o), .done_o(done_o)
  );

  localparam int ROFF [25] = '{0, 1, 14, 12, 11,
                               4, 12, 6, 7, 4,
                               3, 10, 11, 9, 7,
                               9, 13, 15, 5, 8,
                               2, 2, 13, 8, 14};
  localparam logic [15:0] RCT [20] = '{16'h0001, 16'h8082, 16'h808A, 16'h8000, 16'h808B,
                                      16'h0001, 16'h8081, 16'h8009, 16'h008A, 16'h0088,
                                      16'h8009, 16'h000A, 16'h808B, 16'h008B, 16'h8089,
                                      16'h8003, 16'h8002, 16'h0080, 16'h800A, 16'h000A};

  function automatic logic [15:0] rol16(input logic [15:0] v, input int n);
    logic [15:0] r;
    r = v;
    for (int k = 0; k < n; k++) r = {r[14:0], r[15]};
    return r;
  endfunction

  function automatic logic [399:0] perm(input logic [399:0] s);
    logic [15:0] a [25];
    logic [15:0] b [25];
    logic [15:0] c [5];
    logic [15:0] d [5];
    for (int i = 0; i < 25; i++) a[i] = s[16*i +: 16];
    for (int r = 0; r < 20; r++) begin
      for (int x = 0; x < 5; x++) c[x] = a[x] ^ a[x+5] ^ a[x+10] ^ a[x+15] ^ a[x+20];
      for (int x = 0; x < 5; x++) d[x] = c[(x+4)%5] ^ rol16(c[(x+1)%5], 1);
      for (int i = 0; i < 25; i++) a[i] = a[i] ^ d[i%5];
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          b[y + 5*((2*x + 3*y) % 5)] = rol16(a[x+5*y], ROFF[x+5*y]);
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          a[x+5*y] = b[x+5*y] ^ (~b[(x+1)%5 + 5*y] & b[(x+2)%5 + 5*y]);
      a[0] = a[0] ^ RCT[r];
    end
    for (int i = 0; i < 25; i++) s[16*i +: 16] = a[i];
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one command cycle, expected result pushed to the scoreboard
  task automatic issue(input bit s, input bit c, input logic [127:0] blk, input string req);
    @(negedge clk);
    start_i = s;
    cont_i  = c;
    block_i = blk;
    if (s) model = '0;
    model[127:0] = model[127:0] ^ blk;
    model = perm(model);
    exp_q.push_back(model[127:0]);
    tag_q.push_back(req);
    @(negedge clk);
    start_i = 1'b0;
    cont_i  = 1'b0;
    block_i = '0;
  endtask

  task automatic wait_done();
    int n;
    n = done_cnt;
    for (int k = 0; k < 60 && done_cnt == n; k++) @(negedge clk);
    check(done_cnt == n + 1, "R6 done seen", 128'(done_cnt), 128'(n + 1));
  endtask

  task automatic op(input bit s, input bit c, input logic [127:0] blk, input string req);
    issue(s, c, blk, req);
    wait_done();
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (done_o) begin
        done_cnt++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected done", digest_o, last_exp);
        end else begin
          automatic logic [127:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          last_exp = e;
          check(digest_o == e, t, digest_o, e);
          check(busy_run == 20, "R5 busy length", 128'(busy_run), 128'd20);
        end
        busy_run = 0;
      end else if (busy_o) begin
        busy_run++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(busy_o == 1'b0, "R1 busy", 128'(busy_o), 128'd0);
    check(done_o == 1'b0, "R1 done", 128'(done_o), 128'd0);
    check(digest_o == '0, "R1 digest", digest_o, '0);

    op(1'b1, 1'b0, 128'h0, "R2 start zero");
    op(1'b1, 1'b0, 128'h0123456789abcdeffedcba9876543210, "R2 start pattern");
    op(1'b0, 1'b1, 128'h00000000ffffffff00000000ffffffff, "R3 continue");
    op(1'b0, 1'b1, 128'h8000000000000000000000000000001f, "R3 continue 2");
    op(1'b0, 1'b1, 128'h0, "R4 squeeze 1");
    op(1'b0, 1'b1, 128'h0, "R4 squeeze 2");
    op(1'b0, 1'b1, 128'h0, "R4 squeeze 3");

    // R6: digest holds while idle
    repeat (10) @(negedge clk);
    check(digest_o == last_exp, "R6 idle hold", digest_o, last_exp);

    // R8: start and continue together on a non-zero state
    op(1'b1, 1'b1, {4{32'hdeadbeef}}, "R8 start priority");
    op(1'b1, 1'b0, {128{1'b1}}, "R2 start ones");

    // R7: commands during busy are ignored
    issue(1'b1, 1'b0, 128'h5a5a5a5a_a5a5a5a5_0f0f0f0f_f0f0f0f0, "R7 start with noise");
    repeat (4) @(negedge clk);
    start_i = 1'b1; cont_i = 1'b1; block_i = {128{1'b1}};
    @(negedge clk);
    start_i = 1'b0; cont_i = 1'b0; block_i = '0;
    repeat (3) @(negedge clk);
    cont_i = 1'b1; block_i = 128'h1234;
    @(negedge clk);
    cont_i = 1'b0; block_i = '0;
    wait_done();
    begin
      automatic int n = done_cnt;
      repeat (40) @(negedge clk);
      check(done_cnt == n, "R7 no extra done", 128'(done_cnt), 128'(n));
      check(digest_o == last_exp, "R7 result kept", digest_o, last_exp);
    end

    op(1'b0, 1'b1, 128'h0, "R4 squeeze after R7");
    check(exp_q.size() == 0, "R5 scoreboard drained", 128'(exp_q.size()), 128'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule